// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block sits between the interrupt request lines of a small 8-bit processor core and its fetch logic. Each ordinary source has a request line and an enable bit. A source is eligible when its request and its enable are both high, the global interrupt enable is set, and no region lock blocks it. In any cycle with an eligible source, the block raises a take strobe. In the same cycle it emits the program-memory vector address of the winning source and a one-cycle acknowledge to that source, so the source can drop its pending flag.

The vector table holds one slot per source, and each slot is two words wide. Slot 0 belongs to reset and ordinary source `i` uses slot `i+1`, so a lower source index wins. A select input moves the whole table from address 0 to a parameterised boot-section base. The global enable is a flag managed by hardware. Acceptance clears it and a return-from-interrupt strobe sets it. Software can also set or clear it, for example to let a handler be preempted. When the boot lock is active, all sources are held off while the program counter lies in the region that the current vector table does not point into.

Top module: `vec_irq_ctrl`

## Requirements
- R1: `take` is high only when at least one source has its request, its enable bit and the global enable `gie` all at 1. A source with its enable at 0, or any source while `gie` is 0, is never acknowledged.
- R2: When several sources are eligible, the one with the lowest index wins. `irq_ack` is one-hot at that index in the same cycle as `take`, and it is all zero when `take` is low.
- R3: On `take` for source `i`, `vec_addr` = base + 2*(i+1). Slot 0 is reserved for reset. When `take` is low, `vec_addr` equals the base.
- R4: The base is 0 while `vec_sel` is 0 and BOOT_BASE while `vec_sel` is 1.
- R5: `gie` is 0 in the cycle after any cycle with `take` high, whatever else is driven in that cycle.
- R6: Without a take, `reti` or `gie_set` makes `gie` 1 in the next cycle. Otherwise `gie_clr` makes it 0, and otherwise `gie` holds. `reti` and `gie_set` win over `gie_clr`.
- R7: After `gie` has been set again inside a handler, any enabled source is taken again (nested entry).
- R8: With `boot_lock` at 1, no source is taken when `vec_sel`=1 and `pc` < BOOT_BASE, or when `vec_sel`=0 and `pc` >= BOOT_BASE. With `boot_lock` at 0, `pc` has no effect.
- R9: After reset, `gie`, `take` and `irq_ack` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_SRC | Request line per source |
| irq_en | input | NUM_SRC | Enable bit per source |
| gie_set | input | 1 | Software sets global enable |
| gie_clr | input | 1 | Software clears global enable |
| reti | input | 1 | Return-from-interrupt strobe |
| pc | input | PC_W | Current program counter (word address) |
| vec_sel | input | 1 | Vector table in boot section when 1 |
| boot_lock | input | 1 | Region-based interrupt lock active |
| take | output | 1 | Take-interrupt strobe |
| vec_addr | output | PC_W | Vector address of the winning source |
| irq_ack | output | NUM_SRC | One-cycle acknowledge to the winner |
| gie | output | 1 | Global interrupt enable state |

## Verification
The hardest state to reach is a take on a fresh enable. Every take clears `gie`, so each probe of the priority logic must first pulse `gie_set` with all requests low and then present the pattern. The sweep does this for all 256 request words under several enable masks. The bench drives nesting and the precedence cases by overlapping `reti`, `gie_set`, `gie_clr` and a live request in the same cycle. It also sweeps `pc` across the boot boundary for each setting of `vec_sel` and `boot_lock`.

// File: rtl/irq_pkg.sv
package irq_pkg;
   // Vector address of an ordinary source: slot 0 is reset, two words per slot.
   function automatic int unsigned slot_offset(input int unsigned src_idx,
                                               input int unsigned slot_words);
      return (src_idx + 1) * slot_words;
   endfunction
endpackage

// File: rtl/irq_gie_reg.sv
module irq_gie_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic reti,
   input  logic gie_set,
   input  logic gie_clr,
   output logic gie
);
   logic gie_q, gie_d;

   always_comb begin
      gie_d = gie_q;
      if (take)                 gie_d = 1'b0;
      else if (reti || gie_set) gie_d = 1'b1;
      else if (gie_clr)         gie_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gie_q <= 1'b0;
      else        gie_q <= gie_d;
   end

   assign gie = gie_q;

   p_take_clears_gie_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !gie);
   p_reti_sets_gie_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && !take) |=> gie);
endmodule

// File: rtl/irq_region_mask.sv
module irq_region_mask #(
   parameter int unsigned PC_W      = 12,
   parameter int unsigned BOOT_BASE = 12'hC00
) (
   input  logic [PC_W-1:0] pc,
   input  logic            vec_sel,
   input  logic            boot_lock,
   output logic            block_all
);
   localparam logic [PC_W-1:0] BOOT_START = PC_W'(BOOT_BASE);
   logic in_boot;

   assign in_boot   = (pc >= BOOT_START);
   assign block_all = boot_lock && (vec_sel ? !in_boot : in_boot);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int unsigned NUM_SRC = 8,
   localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0] elig,
   output logic [NUM_SRC-1:0] grant,
   output logic [IDX_W-1:0]   idx,
   output logic               any
);
   logic [NUM_SRC:0] seen;
   assign seen[0] = 1'b0;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
      assign seen[g+1] = seen[g] | elig[g];
      assign grant[g]  = elig[g] & ~seen[g];
   end

   assign any = seen[NUM_SRC];

   always_comb begin
      idx = '0;
      for (int k = 0; k < NUM_SRC; k++)
         if (grant[k]) idx = IDX_W'(k);
   end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
   parameter int unsigned NUM_SRC    = 8,
   parameter int unsigned PC_W       = 12,
   parameter int unsigned BOOT_BASE  = 12'hC00,
   parameter int unsigned SLOT_WORDS = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic [NUM_SRC-1:0] irq_en,
   input  logic               gie_set,
   input  logic               gie_clr,
   input  logic               reti,
   input  logic [PC_W-1:0]    pc,
   input  logic               vec_sel,
   input  logic               boot_lock,
   output logic               take,
   output logic [PC_W-1:0]    vec_addr,
   output logic [NUM_SRC-1:0] irq_ack,
   output logic               gie
);
   import irq_pkg::*;
   localparam int unsigned IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int unsigned TBL_SPAN = (NUM_SRC + 1) * SLOT_WORDS;

   initial begin
      assert (NUM_SRC >= 1) else $error("NUM_SRC must be at least 1");
      assert (SLOT_WORDS >= 1) else $error("SLOT_WORDS must be at least 1");
      assert (PC_W < 32 && BOOT_BASE + TBL_SPAN <= (1 << PC_W))
         else $error("vector table does not fit in PC_W");
   end

   logic               block_all;
   logic [NUM_SRC-1:0] elig;
   logic [IDX_W-1:0]   win_idx;
   logic               any;
   logic [PC_W-1:0]    base;

   irq_region_mask #(.PC_W(PC_W), .BOOT_BASE(BOOT_BASE)) u_mask (
      .pc(pc), .vec_sel(vec_sel), .boot_lock(boot_lock), .block_all(block_all)
   );

   assign elig = (gie && !block_all) ? (irq_req & irq_en) : '0;

   irq_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
      .elig(elig), .grant(irq_ack), .idx(win_idx), .any(any)
   );

   irq_gie_reg u_gie (
      .clk(clk), .rst_n(rst_n), .take(any), .reti(reti),
      .gie_set(gie_set), .gie_clr(gie_clr), .gie(gie)
   );

   assign take = any;
   assign base = vec_sel ? PC_W'(BOOT_BASE) : '0;
   assign vec_addr = take ? base + PC_W'(slot_offset(int'(win_idx), SLOT_WORDS)) : base;

   p_take_needs_gie_r1: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> gie);
   p_ack_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_ack) && (take == (irq_ack != '0)));
   p_ack_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack & ~(irq_req & irq_en)) == '0);
   p_lock_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      block_all |-> !take);
endmodule

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
   localparam int N     = 8;
   localparam int PW    = 12;
   localparam int BB    = 12'hC00;
   localparam int CLK_P = 10;

   logic clk = 0, rst_n = 0;
   logic [N-1:0] irq_req = '0, irq_en = '0;
   logic gie_set = 0, gie_clr = 0, reti = 0, vec_sel = 0, boot_lock = 0;
   logic [PW-1:0] pc = '0;
   logic take, gie;
   logic [PW-1:0] vec_addr;
   logic [N-1:0] irq_ack;
   int n_run = 0, n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   vec_irq_ctrl #(.NUM_SRC(N), .PC_W(PW), .BOOT_BASE(BB), .SLOT_WORDS(2)) i_vec_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
      .gie_set(gie_set), .gie_clr(gie_clr), .reti(reti), .pc(pc),
      .vec_sel(vec_sel), .boot_lock(boot_lock), .take(take),
      .vec_addr(vec_addr), .irq_ack(irq_ack), .gie(gie));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic arm();  // one cycle of gie_set with no requests
      @(negedge clk); irq_req = '0; gie_set = 1;
      @(negedge clk); gie_set = 0;
   endtask

   // Present req/en with gie already 1; check comb outputs before the edge.
   task automatic probe(input logic [N-1:0] r, input logic [N-1:0] e, input bit sel);
      int exp_idx; int exp_vec; int base; logic [N-1:0] el;
      irq_req = r; irq_en = e; vec_sel = sel;
      #1;
      el = r & e; base = sel ? BB : 0; exp_idx = -1;
      for (int k = N-1; k >= 0; k--) if (el[k]) exp_idx = k;
      exp_vec = (exp_idx >= 0) ? base + 2*(exp_idx+1) : base;
      chk(take == (exp_idx >= 0), "R1", take, exp_idx >= 0);
      chk(irq_ack == ((exp_idx >= 0) ? N'(1) << exp_idx : '0), "R2", irq_ack,
          (exp_idx >= 0) ? (1 << exp_idx) : 0);
      chk(vec_addr == PW'(exp_vec), sel ? "R4" : "R3", vec_addr, exp_vec);
   endtask

   initial begin
      #(CLK_P*20000);
      n_fail++; n_run++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [N-1:0] ens [3];
      #(CLK_P*2);
      #1;
      chk(!gie && !take && irq_ack == 0, "R9", {gie, take}, 0);
      @(negedge clk); rst_n = 1;
      // R1: gie=0 blocks enabled requests
      irq_req = '1; irq_en = '1; #1;
      chk(!take && irq_ack == 0, "R1", take, 0);
      @(negedge clk); irq_req = '0;

      // R1 R2 R3 R4 sweep
      for (int r = 0; r < 256; r++) begin
         ens[0] = '1; ens[1] = 8'h55; ens[2] = ~N'(r << 1);
         for (int e = 0; e < 3; e++) begin
            arm();
            probe(N'(r), ens[e], (r % 2) == 1);
            @(posedge clk); #1;
            if ((N'(r) & ens[e]) != 0) chk(!gie, "R5", gie, 0);
         end
      end
      vec_sel = 0;

      // R5: take together with reti still clears
      arm();
      irq_req = 8'h10; irq_en = '1; reti = 1; gie_set = 1;
      @(negedge clk); reti = 0; gie_set = 0; irq_req = '0; #1;
      chk(!gie, "R5", gie, 0);

      // R6: reti wins over clr; clr clears; hold
      reti = 1; gie_clr = 1; @(negedge clk); reti = 0; gie_clr = 0; #1;
      chk(gie, "R6", gie, 1);
      @(negedge clk); #1; chk(gie, "R6", gie, 1);
      gie_clr = 1; @(negedge clk); gie_clr = 0; #1;
      chk(!gie, "R6", gie, 0);
      gie_set = 1; gie_clr = 1; @(negedge clk); gie_set = 0; gie_clr = 0; #1;
      chk(gie, "R6", gie, 1);

      // R7: nested entry
      irq_req = 8'h20; #1; chk(take && irq_ack == 8'h20, "R7", irq_ack, 8'h20);
      @(negedge clk); irq_req = 8'h28; #1;
      chk(!take, "R7", take, 0);
      gie_set = 1; @(negedge clk); gie_set = 0; #1;
      chk(take && irq_ack == 8'h08 && vec_addr == 12'd8, "R7", vec_addr, 8);
      @(negedge clk); irq_req = '0;

      // R8: region lock sweep
      for (int l = 0; l < 2; l++)
         for (int s = 0; s < 2; s++)
            for (int p = 0; p < 4096; p += 256) begin
               bit inb; bit blk;
               for (int q = 0; q < 2; q++) begin
                  int pv = (q == 0) ? p : ((p == 0) ? BB - 1 : BB);
                  arm();
                  boot_lock = l[0]; vec_sel = s[0]; pc = PW'(pv);
                  irq_req = 8'h04; irq_en = '1; #1;
                  inb = pv >= BB;
                  blk = l[0] && (s[0] ? !inb : inb);
                  chk(take == !blk, "R8", take, !blk);
                  @(negedge clk); irq_req = '0; boot_lock = 0;
                  gie_clr = 1; @(negedge clk); gie_clr = 0;
               end
            end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule